// File: doc/BRIEF.md
# Power-good strap capture and frequency decode

This block samples three frequency-select strap inputs once, on the first synchronised rising edge of a power-good input, and keeps that code for the rest of the session. The captured code is decoded into a one-hot CPU frequency select and an encoded frequency in MHz. A valid flag tells downstream logic that the selection is final. The other clock domains (100 MHz, 33 MHz, 14.318 MHz, 96 MHz, 48 MHz) do not depend on the code and are not produced here.

If the test-select level is high at the capture moment, the block enters test mode. In that mode the straps stay live: each later strap change reaches the code output after the synchroniser delay. The middle strap then chooses the test output behaviour: either every clock output floats, or every clock output carries the reference clock divided by N. All inputs are asynchronous to the reference clock and pass through a synchroniser. An asynchronous reset re-arms the one-shot capture.

Top module: `fs_strap_latch`

## Requirements
- R1: After reset, `code` is 000, `cpu_sel` is 8'b0000_0001, `cpu_mhz` is 266, and `code_valid`, `test_mode` and `test_out_sel` are all 0.
- R2: Driving `pwr_ok` from 0 to 1 while `code` is still uncaptured loads `{strap_c,strap_b,strap_a}` into `code` exactly SYNC_STAGES+1 clock edges later, and not earlier.
- R3: `code_valid` rises one clock after the capture and stays high until reset.
- R4: Outside test mode, once the capture has happened, later changes on the straps, on `test_sel` and on `pwr_ok` leave `code` and `test_mode` unchanged.
- R5: `test_mode` becomes 1 at the capture if `test_sel` was high together with the `pwr_ok` rise. It then stays 1 until reset.
- R6: In test mode, `code` follows the straps, with SYNC_STAGES+1 clocks of latency.
- R7: `cpu_sel` has exactly one bit set, at position `code`. `cpu_mhz` maps code 0..7 to 266, 133, 200, 166, 333, 100, 400, 200.
- R8: `test_out_sel` equals `code[1]` (the strap_b value) while `test_mode` is 1, with 1 meaning reference divided by N and 0 meaning tri-state. It is 0 outside test mode.
- R9: Asserting `rst_n` low clears the code, the lock and test mode asynchronously, and allows a fresh capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_ok | input | 1 | Power-good level, asynchronous |
| strap_a | input | 1 | Frequency strap, code bit 0 |
| strap_b | input | 1 | Frequency strap, code bit 1; picks the test output behaviour |
| strap_c | input | 1 | Frequency strap, code bit 2 |
| test_sel | input | 1 | High-level test-select detection on the bit-2 strap |
| code | output | 3 | Captured strap code |
| cpu_sel | output | 8 | One-hot CPU frequency select |
| cpu_mhz | output | 9 | Selected CPU frequency in MHz |
| code_valid | output | 1 | Capture complete |
| test_mode | output | 1 | Test mode active |
| test_out_sel | output | 1 | 1 = reference/N, 0 = tri-state (test mode only) |

## Verification
The bench builds the block with the default SYNC_STAGES of 2 and takes the capture latency from that parameter, so each check lands on the exact cycle. The code space has only eight values and test-select has two levels, so the bench runs all sixteen combinations. Each combination starts from reset, captures, checks the decode and then tries to disturb the result. That covers the locked path, the live test path and the re-arm after reset.

// File: rtl/fs_strap_latch.sv
module fs_strap_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       strap_a,
  input  logic       strap_b,
  input  logic       strap_c,
  input  logic       test_sel,
  output logic [2:0] code,
  output logic [7:0] cpu_sel,
  output logic [8:0] cpu_mhz,
  output logic       code_valid,
  output logic       test_mode,
  output logic       test_out_sel
);
  localparam int SW = 5;

  logic [SW-1:0] sync_q [SYNC_STAGES];
  logic          pg_d, locked, test_q, valid_q;
  logic [2:0]    code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {pwr_ok, test_sel, strap_c, strap_b, strap_a};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  wire       pg_s     = sync_q[SYNC_STAGES-1][4];
  wire       tsel_s   = sync_q[SYNC_STAGES-1][3];
  wire [2:0] straps_s = sync_q[SYNC_STAGES-1][2:0];
  wire       capture  = !locked && pg_s && !pg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_d    <= 1'b0;
      locked  <= 1'b0;
      test_q  <= 1'b0;
      valid_q <= 1'b0;
      code_q  <= 3'b000;
    end else begin
      pg_d    <= pg_s;
      valid_q <= locked;
      if (capture) begin
        locked <= 1'b1;
        test_q <= tsel_s;
        code_q <= straps_s;
      end else if (test_q) begin
        code_q <= straps_s;
      end
    end
  end

  always_comb begin
    case (code_q)
      3'd0:    cpu_mhz = 9'd266;
      3'd1:    cpu_mhz = 9'd133;
      3'd2:    cpu_mhz = 9'd200;
      3'd3:    cpu_mhz = 9'd166;
      3'd4:    cpu_mhz = 9'd333;
      3'd5:    cpu_mhz = 9'd100;
      3'd6:    cpu_mhz = 9'd400;
      default: cpu_mhz = 9'd200;
    endcase
  end

  assign code         = code_q;
  assign cpu_sel      = 8'b1 << code_q;
  assign code_valid   = valid_q;
  assign test_mode    = test_q;
  assign test_out_sel = test_q & code_q[1];
endmodule

// File: rtl/fs_strap_latch_chk.sv
module fs_strap_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       locked,
  input logic [2:0] code,
  input logic [7:0] cpu_sel,
  input logic       code_valid,
  input logic       test_mode,
  input logic       test_out_sel
);
  p_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (code == 3'b000 && !code_valid && !test_mode));

  p_valid_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> code_valid);

  p_valid_needs_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> locked);

  p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !test_mode) |=> $stable(code));

  p_test_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> test_mode);

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cpu_sel) == 1);

  p_outsel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    test_out_sel |-> test_mode);
endmodule

bind fs_strap_latch fs_strap_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .locked(locked), .code(code), .cpu_sel(cpu_sel),
  .code_valid(code_valid), .test_mode(test_mode), .test_out_sel(test_out_sel)
);

// File: tb/tb_fs_strap_latch.sv
module tb_fs_strap_latch;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0, strap_a = 1'b0, strap_b = 1'b0, strap_c = 1'b0, test_sel = 1'b0;
  logic [2:0] code;
  logic [7:0] cpu_sel;
  logic [8:0] cpu_mhz;
  logic code_valid, test_mode, test_out_sel;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fs_strap_latch #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .strap_a(strap_a), .strap_b(strap_b),
    .strap_c(strap_c), .test_sel(test_sel), .code(code), .cpu_sel(cpu_sel),
    .cpu_mhz(cpu_mhz), .code_valid(code_valid), .test_mode(test_mode),
    .test_out_sel(test_out_sel)
  );

  function automatic int mhz_of(int k);
    int base;
    base = (k[0] == 1'b0) ? 266 : 133;
    case (k)
      2: base = 200;
      3: base = 166;
      4: base = 333;
      5: base = 100;
      6: base = 400;
      7: base = 200;
      default: ;
    endcase
    return base;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_straps(input int k);
    {strap_c, strap_b, strap_a} = k[2:0];
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 2; t++) begin
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        rst_n = 1'b0; pwr_ok = 1'b0;
        set_straps(k); test_sel = t[0];
        @(negedge clk);
        // R9: async clear, then fresh capture
        chk("R9 test_mode cleared", test_mode, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 code", code, 0);
        chk("R1 valid", code_valid, 0);
        chk("R1 cpu_sel", cpu_sel, 1);
        chk("R1 cpu_mhz", cpu_mhz, 266);
        chk("R1 test_out_sel", test_out_sel, 0);
        pwr_ok = 1'b1;
        repeat (SYNC) @(negedge clk);
        chk("R2 not early", code, 0);
        @(negedge clk);
        chk("R2 captured", code, k);
        chk("R3 valid late", code_valid, 0);
        @(negedge clk);
        chk("R3 valid", code_valid, 1);
        chk("R7 cpu_sel", cpu_sel, 1 << k);
        chk("R7 cpu_mhz", cpu_mhz, mhz_of(k));
        chk("R5 test_mode", test_mode, t);
        chk("R8 test_out_sel", test_out_sel, t & ((k >> 1) & 1));
        set_straps(7 - k); test_sel = ~t[0];
        pwr_ok = 1'b0;
        repeat (4) @(negedge clk);
        pwr_ok = 1'b1;
        repeat (6) @(negedge clk);
        if (t == 0) begin
          chk("R4 code held", code, k);
          chk("R4 test_mode held", test_mode, 0);
          chk("R4 valid held", code_valid, 1);
        end else begin
          chk("R6 code live", code, 7 - k);
          chk("R5 test_mode sticky", test_mode, 1);
          chk("R8 test_out_sel live", test_out_sel, ((7 - k) >> 1) & 1);
          chk("R7 cpu_mhz live", cpu_mhz, mhz_of(7 - k));
        end
      end
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule